// File: doc/BRIEF.md
# Device Interrupt Request Logic

This block is the interrupt front end of a peripheral. A ready event, the same strobe that raises the device's ready status, marks an interrupt as pending. Software controls an enable bit that decides whether the pending request reaches the processor. Software can also cancel a pending request explicitly.

The processor's request input is a shared, active-low wired-OR line. The block never drives that line high. It only asserts a pull-down enable, `irq_pull`, while a request is pending and enabled. The processor answers with an acknowledge. While that acknowledge is high and this device is the one pulling the line, the block enables its data drivers. It places a 24-bit identification word on them: an 8-bit type code in the low byte and a 16-bit information word above it. The acknowledge edge then retires the pending request. The type code and the information word are fixed per instance through parameters.

Top module: `dev_irq_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pending and enable state are 0, `irq_pull` is 0 and `vec_oe` is 0.
- R2: A ready event sampled at a clock edge makes the request pending from that edge on.
- R3: An enable write sampled at a clock edge loads `en_wdata` into the enable bit. Clearing the enable hides a pending request without discarding it, so setting the enable again brings back `irq_pull` with no new ready event.
- R4: `irq_pull` is 1 exactly when the request is pending and enabled. Otherwise the line is released (0).
- R5: `vec_oe` is 1 only while `irq_ack` is high and `irq_pull` is 1. Whenever `vec_oe` is 0, `vec_data` is all zeros.
- R6: While `vec_oe` is 1, `vec_data[7:0]` equals the type code parameter and `vec_data[23:8]` equals the information word parameter.
- R7: A clock edge at which `irq_ack` is high while `irq_pull` is 1 clears the pending request.
- R8: A clear write sampled at a clock edge clears the pending request.
- R9: A ready event at the same edge as a clear write or an acknowledge wins, and the request stays pending.
- R10: An acknowledge while `irq_pull` is 0 has no effect. `vec_oe` stays 0, and a request pending under a cleared enable survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready_evt | input | 1 | Device-ready strobe, sets the pending request |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written into the enable bit |
| clr_wr | input | 1 | Write strobe that cancels a pending request |
| irq_ack | input | 1 | Processor acknowledge |
| irq_pull | output | 1 | 1 = pull the shared active-low request line low |
| vec_oe | output | 1 | Output enable of the identification drivers |
| vec_data | output | 24 | Identification word {information, type code} |

## Verification
A wrong pending bit shows at the ports in the first cycle after the edge that set it wrongly, provided the enable is 1: `irq_pull` is then wrong. A wrong pending bit under a cleared enable stays hidden until the enable is written back to 1. A wrong enable bit also shows on `irq_pull` one cycle after the write, but only while a request is pending. Faults in the output-enable gating or in the identification word appear combinationally during any acknowledge cycle in which the device is pulling the line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPE_W = 8;
  localparam int INFO_W = 16;
  localparam int VEC_W  = TYPE_W + INFO_W;

  typedef logic [VEC_W-1:0] vec_t;

  // identification word: information word above the type code
  function automatic vec_t vec_word(input logic [TYPE_W-1:0] code,
                                    input logic [INFO_W-1:0] info);
    return {info, code};
  endfunction

  // next pending state: set takes priority over any clear source
  function automatic logic pend_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_pend_ff.sv
module irq_pend_ff
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next(pend_q, set_i, clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= 1'b0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_vector_drv.sv
module irq_vector_drv
  import irq_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h40,
  parameter logic [INFO_W-1:0] INFO_WORD = 16'h0000
) (
  input  logic       ack_i,
  input  logic       active_i,
  output logic       oe_o,
  output logic [VEC_W-1:0] data_o
);
  localparam vec_t ID_WORD = vec_word(TYPE_CODE, INFO_WORD);

  always_comb begin
    oe_o   = ack_i & active_i;
    data_o = oe_o ? ID_WORD : '0;
  end
endmodule

// File: rtl/dev_irq_if.sv
module dev_irq_if
  import irq_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h40,
  parameter logic [INFO_W-1:0] INFO_WORD = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_evt,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             clr_wr,
  input  logic             irq_ack,
  output logic             irq_pull,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_data
);
  // named internal events, observed by the checker
  logic pend_q;
  logic en_q;
  logic req_active;
  logic ack_take;
  logic pend_clr;

  assign req_active = pend_q & en_q;
  assign ack_take   = irq_ack & req_active;
  assign pend_clr   = ack_take | clr_wr;

  irq_pend_ff u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ready_evt),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  irq_enable_ff u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (en_wdata),
    .en_o    (en_q)
  );

  irq_vector_drv #(
    .TYPE_CODE (TYPE_CODE),
    .INFO_WORD (INFO_WORD)
  ) u_vec (
    .ack_i    (irq_ack),
    .active_i (req_active),
    .oe_o     (vec_oe),
    .data_o   (vec_data)
  );

  assign irq_pull = req_active;
endmodule

// File: rtl/dev_irq_if_chk.sv
module dev_irq_if_chk
  import irq_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h40,
  parameter logic [INFO_W-1:0] INFO_WORD = 16'h0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready_evt,
  input logic             en_wr,
  input logic             en_wdata,
  input logic             clr_wr,
  input logic             irq_ack,
  input logic             irq_pull,
  input logic             vec_oe,
  input logic [VEC_W-1:0] vec_data,
  input logic             pend_q,
  input logic             en_q
);
  // R1: reset leaves the line released
  a_r1_reset_release: assert property (@(posedge clk)
    !rst_n |=> !irq_pull);

  // R2
  a_r2_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ready_evt |=> pend_q);

  // R3
  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(en_wdata)));

  // R5
  a_r5_oe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (irq_ack && irq_pull));

  a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> (vec_data == '0));

  // R6
  a_r6_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_data[TYPE_W-1:0] == TYPE_CODE &&
                vec_data[VEC_W-1:TYPE_W] == INFO_WORD));

  // R7
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_pull && !ready_evt) |=> !pend_q);

  // R8
  a_r8_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ready_evt) |=> !pend_q);

  // R10
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_pull && !clr_wr && !ready_evt) |=> $stable(pend_q));
endmodule

bind dev_irq_if dev_irq_if_chk #(
  .TYPE_CODE (TYPE_CODE),
  .INFO_WORD (INFO_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready_evt (ready_evt),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .clr_wr    (clr_wr),
  .irq_ack   (irq_ack),
  .irq_pull  (irq_pull),
  .vec_oe    (vec_oe),
  .vec_data  (vec_data),
  .pend_q    (pend_q),
  .en_q      (en_q)
);

// File: tb/test_dev_irq_if.sv
`timescale 1ns/1ps
module test_dev_irq_if;
  localparam logic [7:0]  T_CODE = 8'hA5;
  localparam logic [15:0] T_INFO = 16'h3C69;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready_evt = 1'b0, en_wr = 1'b0, en_wdata = 1'b0;
  logic        clr_wr = 1'b0, irq_ack = 1'b0;
  logic        irq_pull, vec_oe;
  logic [23:0] vec_data;

  int checks = 0;
  int errors = 0;
  logic m_pend = 1'b0, m_en = 1'b0;

  always #4 clk = ~clk;

  dev_irq_if #(.TYPE_CODE(T_CODE), .INFO_WORD(T_INFO)) i_dev_irq_if (
    .clk(clk), .rst_n(rst_n), .ready_evt(ready_evt), .en_wr(en_wr),
    .en_wdata(en_wdata), .clr_wr(clr_wr), .irq_ack(irq_ack),
    .irq_pull(irq_pull), .vec_oe(vec_oe), .vec_data(vec_data));

  function automatic logic exp_pull(input logic p, input logic e);
    return p && e;
  endfunction

  function automatic logic [23:0] exp_data(input logic oe);
    if (oe) return {T_INFO, T_CODE};
    return 24'h0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs, update model at posedge
  task automatic step(input logic rdy, input logic ew, input logic ed,
                      input logic clr, input logic ack, input string req);
    logic ep, eo, take;
    @(negedge clk);
    ready_evt = rdy; en_wr = ew; en_wdata = ed; clr_wr = clr; irq_ack = ack;
    #1;
    ep = exp_pull(m_pend, m_en);
    eo = ack && ep;
    chk(req, "irq_pull (R4)", {23'h0, irq_pull}, {23'h0, ep});
    chk(req, "vec_oe (R5)", {23'h0, vec_oe}, {23'h0, eo});
    chk(req, "vec_data (R6)", vec_data, exp_data(eo));
    @(posedge clk);
    take = ack && ep;
    m_pend = rdy || (m_pend && !(take || clr));
    if (ew) m_en = ed;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "irq_pull in reset", {23'h0, irq_pull}, 24'h0);
    chk("R1", "vec_oe in reset", {23'h0, vec_oe}, 24'h0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 1, "R1");           // first cycle: ack ignored
    // R2 without enable: pending hidden; R3 enable exposes it
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, "R10");          // ack while masked
    step(0, 1, 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");           // pull visible, no new event
    step(0, 1, 0, 0, 0, "R3");           // mask again
    step(0, 1, 1, 0, 0, "R3");           // still pending
    step(0, 0, 0, 0, 1, "R7");           // ack with id word
    step(0, 0, 0, 0, 0, "R7");           // cleared
    step(1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 1, 0, "R9");           // set beats clear
    step(1, 0, 0, 0, 1, "R9");           // set beats ack
    step(0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 2) == 0, "R4");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule